// File: doc/BRIEF.md
# Gauge driver command decoder

This block sits between the frame receiver of a dual-gauge stepper driver and its motion logic. Each command arrives as one 16-bit parallel word together with a one-cycle valid pulse. The block decodes the word and keeps a small bank of write-only control registers. These hold a 12-bit target pointer position for each of the two gauges, and for each gauge a set of return-to-zero controls: enable, unconditional mode and direction.

Before any register is touched, each command type is screened against its own reserved-bit rule. A command that fails its rule changes nothing and latches a sticky error flag. The motion logic reads the register values straight from the outputs. A one-cycle strobe tells it when something it depends on has actually changed.

Top module: `gauge_cmd_decoder`

## Requirements
- R1: A frame is taken only on a rising clock edge where `frame_valid` is high. Bits 15:13 are the address and bits 12:0 are the data field D12:D0. Register outputs show the result of a frame right after the edge that accepts it. A word presented with `frame_valid` low changes nothing.
- R2: Address 3'b010 loads D11:D0 into the gauge 0 target position. Address 3'b011 loads D11:D0 into the gauge 1 target position. Every value from 0 to 4095 is stored exactly, provided D12 is 0.
- R3: A position command (address 3'b010 or 3'b011) with D12 = 1 is rejected. No register changes and the error flag is set.
- R4: Address 3'b100 is a return-to-zero command. D0 selects the gauge (0 = gauge 0, 1 = gauge 1). That gauge's enable takes D1, its unconditional-mode bit takes D4 (0 = automatic stop on stall, 1 = unconditional) and its clockwise bit takes D2 (0 = counter-clockwise, 1 = clockwise). The other gauge's fields and both positions stay unchanged.
- R5: A return-to-zero command in which any of D12:D5 or D3 is 1 is rejected. No register changes and the error flag is set.
- R6: Frames with addresses 3'b000, 3'b001, 3'b101, 3'b110 or 3'b111 change no register and do not set the error flag, whatever their data.
- R7: The error flag stays set until `err_clear` is high on a clock edge. If a rejected command arrives on the same edge as `err_clear`, the flag stays set.
- R8: `update_strobe` is high for exactly the one cycle after an accepted command that alters at least one stored position or return-to-zero field. It stays low after a write that leaves every field unchanged, and in every other cycle.
- R9: While `rst_n` is low, both positions read 0, every return-to-zero field reads 0 (disabled, automatic, counter-clockwise), and `update_strobe` and `cmd_error` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | Qualifies `frame_word` for one cycle |
| frame_word | input | 16 | Address in 15:13, data D12:D0 in 12:0 |
| err_clear | input | 1 | Clears the sticky error flag |
| pos0_target | output | 12 | Gauge 0 target pointer position |
| pos1_target | output | 12 | Gauge 1 target pointer position |
| rtz_enable | output | 2 | Return-to-zero enable, bit g for gauge g |
| rtz_uncond | output | 2 | Unconditional-mode select, bit g for gauge g |
| rtz_cw | output | 2 | Clockwise direction select, bit g for gauge g |
| update_strobe | output | 1 | One-cycle pulse after a register change |
| cmd_error | output | 1 | Sticky flag for a rejected command |

## Verification
The bench sweeps the whole return-to-zero low field, every reserved bit on its own, and positions across the full 0 to 4095 range for both gauges. A decoder that confused the gauge select bit would corrupt the idle gauge's controls. A decoder that checked reserved bits only after writing would leave a partial update behind a raised error. Rewriting an unchanged value targets a strobe that fires on every write instead of on every change. Unused addresses carrying a set D12 catch a decoder that applies the position reserved-bit rule to every address. A rejected frame arriving together with the clear input catches a flag that lets the clear win.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 13;
    localparam int FRAME_W = ADDR_W + DATA_W;
    localparam int POS_W   = 12;
    localparam int N_GAUGE = 2;
    localparam int GSEL_W  = $clog2(N_GAUGE);

    localparam logic [ADDR_W-1:0] ADDR_POS0 = 3'b010;
    localparam logic [ADDR_W-1:0] ADDR_POS1 = 3'b011;
    localparam logic [ADDR_W-1:0] ADDR_RTZ  = 3'b100;

    // Data-field positions inside a return-to-zero command
    localparam int RTZ_SEL_BIT    = 0;
    localparam int RTZ_EN_BIT     = 1;
    localparam int RTZ_DIR_BIT    = 2;
    localparam int RTZ_RSV_LO_BIT = 3;
    localparam int RTZ_MODE_BIT   = 4;
    localparam int RTZ_RSV_HI_LSB = 5;

    typedef enum logic [1:0] {
        CMD_IDLE,
        CMD_POS,
        CMD_RTZ,
        CMD_REJECT
    } cmd_kind_e;

    typedef struct packed {
        logic en;
        logic uncond;
        logic cw;
    } rtz_ctl_t;

    typedef struct packed {
        cmd_kind_e          kind;
        logic [GSEL_W-1:0]  gsel;
        logic [POS_W-1:0]   pos;
        rtz_ctl_t           rtz;
    } cmd_t;

    typedef struct packed {
        logic [N_GAUGE-1:0][POS_W-1:0] pos;
        rtz_ctl_t [N_GAUGE-1:0]        rtz;
        logic                          strobe;
        logic                          err;
    } bank_t;

endpackage

// File: rtl/gcd_frame_check.sv
module gcd_frame_check
    import gcd_pkg::*;
(
    input  logic               valid_i,
    input  logic [FRAME_W-1:0] frame_i,
    output cmd_t               cmd_o
);

    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              pos_rsv_bad;
    logic              rtz_rsv_bad;

    assign addr = frame_i[FRAME_W-1 -: ADDR_W];
    assign data = frame_i[DATA_W-1:0];

    // Each command type has its own reserved-bit screen
    assign pos_rsv_bad = |data[DATA_W-1:POS_W];
    assign rtz_rsv_bad = (|data[DATA_W-1:RTZ_RSV_HI_LSB]) | data[RTZ_RSV_LO_BIT];

    always_comb begin
        cmd_o            = '0;
        cmd_o.kind       = CMD_IDLE;
        cmd_o.pos        = data[POS_W-1:0];
        cmd_o.rtz.en     = data[RTZ_EN_BIT];
        cmd_o.rtz.uncond = data[RTZ_MODE_BIT];
        cmd_o.rtz.cw     = data[RTZ_DIR_BIT];
        if (valid_i) begin
            unique case (addr)
                ADDR_POS0, ADDR_POS1: begin
                    cmd_o.kind = pos_rsv_bad ? CMD_REJECT : CMD_POS;
                    cmd_o.gsel = addr[GSEL_W-1:0];
                end
                ADDR_RTZ: begin
                    cmd_o.kind = rtz_rsv_bad ? CMD_REJECT : CMD_RTZ;
                    cmd_o.gsel = data[RTZ_SEL_BIT +: GSEL_W];
                end
                default: cmd_o.kind = CMD_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/gcd_reg_bank.sv
module gcd_reg_bank
    import gcd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  cmd_t  cmd_i,
    input  logic  err_clr_i,
    output bank_t bank_o
);

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d        = bank_q;
        bank_d.strobe = 1'b0;
        unique case (cmd_i.kind)
            CMD_POS: bank_d.pos[cmd_i.gsel] = cmd_i.pos;
            CMD_RTZ: bank_d.rtz[cmd_i.gsel] = cmd_i.rtz;
            default: ;
        endcase
        bank_d.strobe = (bank_d.pos != bank_q.pos) || (bank_d.rtz != bank_q.rtz);
        // A fresh rejection outranks a clear on the same edge
        if (cmd_i.kind == CMD_REJECT) begin
            bank_d.err = 1'b1;
        end else if (err_clr_i) begin
            bank_d.err = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign bank_o = bank_q;

endmodule

// File: rtl/gauge_cmd_decoder.sv
module gauge_cmd_decoder
    import gcd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_valid,
    input  logic [FRAME_W-1:0]  frame_word,
    input  logic                err_clear,
    output logic [POS_W-1:0]    pos0_target,
    output logic [POS_W-1:0]    pos1_target,
    output logic [N_GAUGE-1:0]  rtz_enable,
    output logic [N_GAUGE-1:0]  rtz_uncond,
    output logic [N_GAUGE-1:0]  rtz_cw,
    output logic                update_strobe,
    output logic                cmd_error
);

    cmd_t  cmd;
    bank_t bank;

    gcd_frame_check u_check (
        .valid_i (frame_valid),
        .frame_i (frame_word),
        .cmd_o   (cmd)
    );

    gcd_reg_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_i     (cmd),
        .err_clr_i (err_clear),
        .bank_o    (bank)
    );

    assign pos0_target = bank.pos[0];
    assign pos1_target = bank.pos[1];

    for (genvar g = 0; g < N_GAUGE; g++) begin : g_rtz_out
        assign rtz_enable[g] = bank.rtz[g].en;
        assign rtz_uncond[g] = bank.rtz[g].uncond;
        assign rtz_cw[g]     = bank.rtz[g].cw;
    end

    assign update_strobe = bank.strobe;
    assign cmd_error     = bank.err;

endmodule

// File: rtl/gcd_checker.sv
module gcd_checker
    import gcd_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                frame_valid,
    input logic [FRAME_W-1:0]  frame_word,
    input logic                err_clear,
    input logic [POS_W-1:0]    pos0_target,
    input logic [POS_W-1:0]    pos1_target,
    input logic [N_GAUGE-1:0]  rtz_enable,
    input logic [N_GAUGE-1:0]  rtz_uncond,
    input logic [N_GAUGE-1:0]  rtz_cw,
    input logic                update_strobe,
    input logic                cmd_error
);

    logic [ADDR_W-1:0] c_addr;
    logic              c_is_pos;
    logic              c_is_rtz;
    logic              c_bad;
    logic [2*POS_W+3*N_GAUGE-1:0] c_regs;

    assign c_addr   = frame_word[15:13];
    assign c_is_pos = frame_valid && (c_addr == ADDR_POS0 || c_addr == ADDR_POS1);
    assign c_is_rtz = frame_valid && (c_addr == ADDR_RTZ);
    assign c_bad    = (c_is_pos && frame_word[12]) ||
                      (c_is_rtz && ((frame_word[12:5] != 8'd0) || frame_word[3]));
    assign c_regs   = {pos0_target, pos1_target, rtz_enable, rtz_uncond, rtz_cw};

    p_reset_r9: assert property (@(posedge clk)
        !rst_n |-> (c_regs == '0 && !update_strobe && !cmd_error));

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |=> $stable(c_regs));

    p_pos0_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && c_addr == ADDR_POS0 && !frame_word[12])
        |=> pos0_target == $past(frame_word[11:0]));

    p_pos1_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && c_addr == ADDR_POS1 && !frame_word[12])
        |=> pos1_target == $past(frame_word[11:0]));

    // R3 and R5: a rejected frame freezes the bank and raises the flag
    p_reject_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        c_bad |=> ($stable(c_regs) && cmd_error));

    p_rtz_keep_g1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_is_rtz && !c_bad && !frame_word[0])
        |=> ($stable({rtz_enable[1], rtz_uncond[1], rtz_cw[1]}) &&
             $stable({pos0_target, pos1_target})));

    p_rtz_keep_g0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_is_rtz && !c_bad && frame_word[0])
        |=> ($stable({rtz_enable[0], rtz_uncond[0], rtz_cw[0]}) &&
             $stable({pos0_target, pos1_target})));

    p_other_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !c_is_pos && !c_is_rtz)
        |=> ($stable(c_regs) && (cmd_error == $past(cmd_error && !err_clear))));

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_error && !err_clear) |=> cmd_error);

    p_strobe_real_r8: assert property (@(posedge clk) disable iff (!rst_n)
        update_strobe |-> !$stable(c_regs));

    p_strobe_seen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(c_regs) |-> update_strobe);

endmodule

bind gauge_cmd_decoder gcd_checker u_gcd_checker (.*);

// File: tb/gauge_cmd_decoder_bench.sv
module gauge_cmd_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_valid = 1'b0;
    logic [15:0] frame_word = '0;
    logic        err_clear = 1'b0;
    logic [11:0] pos0_target, pos1_target;
    logic [1:0]  rtz_enable, rtz_uncond, rtz_cw;
    logic        update_strobe, cmd_error;

    int n_chk = 0;
    int n_bad = 0;

    logic [11:0] m_pos [2];
    logic [1:0]  m_en, m_unc, m_cw;
    logic        m_strobe, m_err;

    always #10 clk = ~clk;

    gauge_cmd_decoder u_gauge_cmd_decoder (
        .clk, .rst_n, .frame_valid, .frame_word, .err_clear,
        .pos0_target, .pos1_target, .rtz_enable, .rtz_uncond, .rtz_cw,
        .update_strobe, .cmd_error
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, 32'(pos0_target), 32'(m_pos[0]));
        chk(tag, 32'(pos1_target), 32'(m_pos[1]));
        chk(tag, 32'({rtz_enable, rtz_uncond, rtz_cw}), 32'({m_en, m_unc, m_cw}));
        chk({tag, "/R8"}, 32'(update_strobe), 32'(m_strobe));
        chk({tag, "/R7"}, 32'(cmd_error), 32'(m_err));
    endtask

    // Expected-state update written from the requirements
    task automatic model(input logic [15:0] f, input logic clr);
        logic [2:0]  a;
        logic [12:0] d;
        logic        bad;
        logic        chg;
        int          g;
        a = f[15:13];
        d = f[12:0];
        bad = 1'b0;
        chg = 1'b0;
        if (a == 3'b010 || a == 3'b011) begin
            if (d[12]) bad = 1'b1;
            else begin
                g = (a == 3'b011) ? 1 : 0;
                if (m_pos[g] != d[11:0]) chg = 1'b1;
                m_pos[g] = d[11:0];
            end
        end else if (a == 3'b100) begin
            if (d[12:5] != 8'd0 || d[3]) bad = 1'b1;
            else begin
                g = d[0] ? 1 : 0;
                if (m_en[g] != d[1] || m_unc[g] != d[4] || m_cw[g] != d[2]) chg = 1'b1;
                m_en[g]  = d[1];
                m_unc[g] = d[4];
                m_cw[g]  = d[2];
            end
        end
        m_strobe = chg;
        if (bad) m_err = 1'b1;
        else if (clr) m_err = 1'b0;
    endtask

    task automatic send(input logic [15:0] f, input logic clr, input string tag);
        @(negedge clk);
        frame_word  = f;
        frame_valid = 1'b1;
        err_clear   = clr;
        model(f, clr);
        @(posedge clk);
        #1;
        check_all(tag);
        @(negedge clk);
        frame_valid = 1'b0;
        err_clear   = 1'b0;
        m_strobe    = 1'b0;
    endtask

    task automatic ghost(input logic [15:0] f, input string tag);
        @(negedge clk);
        frame_word  = f;
        frame_valid = 1'b0;
        @(posedge clk);
        #1;
        m_strobe = 1'b0;
        check_all(tag);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        m_pos[0] = '0; m_pos[1] = '0;
        m_en = '0; m_unc = '0; m_cw = '0;
        m_strobe = 1'b0; m_err = 1'b0;

        // R9: reset state
        repeat (3) @(posedge clk);
        #1;
        check_all("R9");
        @(negedge clk);
        rst_n = 1'b1;

        // R2: position sweep for both gauges, including both ends
        for (int v = 0; v < 4096; v += 13) begin
            send({3'b010, 1'b0, 12'(v)}, 1'b0, "R2");
            send({3'b011, 1'b0, 12'(4095 - v)}, 1'b0, "R2");
        end
        send({3'b010, 1'b0, 12'd4095}, 1'b0, "R2");
        send({3'b011, 1'b0, 12'd0}, 1'b0, "R2");

        // R8: rewriting an unchanged value must not strobe
        send({3'b010, 1'b0, 12'd4095}, 1'b0, "R8");
        send({3'b011, 1'b0, 12'd0}, 1'b0, "R8");

        // R1: a word with valid low is ignored
        ghost({3'b010, 1'b0, 12'h5a5}, "R1");
        ghost({3'b100, 13'h0013}, "R1");

        // R3: reserved D12 set on positions
        for (int v = 0; v < 4096; v += 511) begin
            send({3'b010, 1'b1, 12'(v)}, 1'b0, "R3");
            send({3'b011, 1'b1, 12'(v)}, 1'b0, "R3");
        end

        // R7: flag stays set through accepted and ignored frames, then clears
        send({3'b000, 13'h1fff}, 1'b0, "R7");
        send({3'b010, 1'b0, 12'd77}, 1'b0, "R7");
        send({3'b010, 1'b1, 12'd9}, 1'b1, "R7");
        send({3'b111, 13'h0000}, 1'b1, "R7");

        // R4 and R5: whole low field of return-to-zero, two passes
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < 32; k++) begin
                send({3'b100, 8'd0, 5'(k ^ (p * 31))}, 1'((k % 3) == 0),
                     (((k ^ (p * 31)) & 8) != 0) ? "R5" : "R4");
            end
        end

        // R5: each high reserved bit alone on an otherwise enabling command
        for (int b = 5; b < 13; b++) begin
            send({3'b100, 13'h0017 | 13'(1 << b)}, 1'b0, "R5");
            send({3'b100, 13'h0000}, 1'b1, "R5");
        end

        // R6: unused addresses with assorted data, D12 set included
        for (int a = 0; a < 8; a++) begin
            if (a >= 2 && a <= 4) continue;
            send({3'(a), 13'h1fff}, 1'b0, "R6");
            send({3'(a), 13'h1003}, 1'b0, "R6");
            send({3'(a), 13'h0017}, 1'b0, "R6");
        end

        // R4: per-gauge isolation with opposite settings
        send({3'b100, 8'd0, 5'b10111}, 1'b0, "R4");
        send({3'b100, 8'd0, 5'b00000}, 1'b0, "R4");
        send({3'b100, 8'd0, 5'b00110}, 1'b0, "R4");
        send({3'b100, 8'd0, 5'b00110}, 1'b0, "R8");

        repeat (2) @(posedge clk);
        summary();
        $finish;
    end

endmodule